// File: doc/BRIEF.md
# Bus Peripheral Decoder with Wait-States

This block is the slave side of a small peripheral register bank sitting on a processor bus with a 16-bit address. It watches the address, an optional memory/IO select line and the read and write strobes. It decides whether the current access belongs to the peripheral, then reads or writes one of four 8-bit registers. A parameter picks how the peripheral is located. In memory-mapped mode the top half of the address space (bit 15 set) belongs to the peripheral, and the bottom half is memory that the block ignores. In isolated I/O mode the memory/IO select line decides, and only the low address bits that pick a register are compared.

The bus handshake is a single active-high ready line that the master samples on each rising edge. A register that answers at once keeps ready high, so the access completes on the first edge. One register is slow. While it is addressed by a live read or write, ready drops in the same cycle and stays low for a parameterised number of clocks. The master applies back-pressure to itself by holding address, strobes and write data stable until it sees ready high at an edge. It then completes the cycle and either drops the strobes or starts a new access.

Top module: `bus_periph_decoder`

## Requirements
- R1: After reset all four registers read as 0x00, ready is high, the read-enable output is low and read data is 0x00.
- R2: In memory-mapped mode (MODE = MAP_MEMORY) an access hits the peripheral only when address bit 15 is 1 (0x8000 to 0xFFFF). The register index is address bits [1:0], and the bits in between are not compared, so 0xC001 aliases 0x8001. Accesses below 0x8000 change no register, keep ready high and leave the read-enable low. The memory/IO line has no effect.
- R3: In isolated I/O mode (MODE = MAP_ISOLATED) an access hits only when the memory/IO line is 1, for any address. With the line at 0 the access is ignored: no register changes, ready stays high and the read-enable stays low.
- R4: In isolated I/O mode only address bits [1:0] are compared, so 0xFF02 and 0x0002 select the same register.
- R5: Ready is high whenever neither the read nor the write strobe is active, and for every access that hits a fast register (indices 0, 1 and 2).
- R6: A read or write that hits the slow register (index 3) pulls ready low in the same cycle. Ready stays low for exactly SLOW_LAT clocks (default 3) and then rises, so the access completes on edge SLOW_LAT+1.
- R7: A write is stored on the rising edge where ready is high, the write strobe is active and the access hits. The value can be read back on a later access.
- R8: Read data equals the addressed register, and the read-enable is high, only while a read hits. At all other times read data is 0x00 and the read-enable is low, including during writes.
- R9: An address that would hit the slow register, presented without any strobe, never lowers ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| bus_mio | input | 1 | Memory/IO select, 1 = I/O space (isolated mode only) |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not reading |
| bus_rdata_oe | output | 1 | High while read data is driven |
| bus_ready | output | 1 | Ready, low inserts a wait state |

## Verification
The decoder is driven in both modes, with one instance per mode. Each instance sees addresses in both halves of the space, aliased addresses that differ only in uncompared bits, and both settings of the memory/IO line. This separates a correct hit test from one that compares too many bits or too few. Reads and writes go to fast and slow registers alike. Counting the wait states per access shows whether ready drops only for a decoded command to the slow register, and whether it stays low for the exact latency. Readback after writes to the slow register confirms that the data is stored on the completing edge. An address with no strobe shows whether ready depends on the command.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  typedef enum logic {MAP_MEMORY = 1'b0, MAP_ISOLATED = 1'b1} map_mode_e;
endpackage

// File: rtl/bpd_decode.sv
module bpd_decode #(
  parameter bpd_pkg::map_mode_e MODE = bpd_pkg::MAP_MEMORY,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mio_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              access_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic hit;

  generate
    if (MODE == bpd_pkg::MAP_MEMORY) begin : g_mem
      assign hit = addr_i[ADDR_W-1];
    end else begin : g_iso
      assign hit = mio_i;
    end
  endgenerate

  assign idx_o    = addr_i[IDX_W-1:0];
  assign access_o = hit & (rd_i | wr_i);

  // R2/R3: without a strobe there is never a decoded access
  p_no_cmd_no_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_i || wr_i) |-> !access_o);
endmodule

// File: rtl/bpd_wait.sv
module bpd_wait #(
  parameter int SLOW_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic ready_o
);
  localparam int CNT_W = $clog2(SLOW_LAT + 1);
  logic [CNT_W-1:0] cnt;

  assign ready_o = !req_i || (cnt == CNT_W'(SLOW_LAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (req_i && !ready_o) cnt <= cnt + 1'b1;
    else                       cnt <= '0;
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(SLOW_LAT));
  p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_i || ready_o) |=> cnt == '0);
endmodule

// File: rtl/bpd_regbank.sv
module bpd_regbank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                regs[g] <= '0;
        else if (we_i && idx_i == IDX_W'(g))       regs[g] <= wdata_i;
      end
    end
  endgenerate

  assign rdata_o = regs[idx_i];

  p_hold_without_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(regs));
endmodule

// File: rtl/bus_periph_decoder.sv
module bus_periph_decoder #(
  parameter bpd_pkg::map_mode_e MODE = bpd_pkg::MAP_MEMORY,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int SLOW_IDX = 3,
  parameter int SLOW_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_mio,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  output logic              bus_ready
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic             access;
  logic [IDX_W-1:0] idx;
  logic             slow_req;
  logic             we;
  logic [DATA_W-1:0] bank_rdata;

  bpd_decode #(.MODE(MODE), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .mio_i(bus_mio),
    .rd_i(bus_rd), .wr_i(bus_wr), .access_o(access), .idx_o(idx)
  );

  assign slow_req = access && (idx == IDX_W'(SLOW_IDX));

  bpd_wait #(.SLOW_LAT(SLOW_LAT)) u_wait (
    .clk(clk), .rst_n(rst_n), .req_i(slow_req), .ready_o(bus_ready)
  );

  assign we = access && bus_wr && bus_ready;

  bpd_regbank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we_i(we), .idx_i(idx),
    .wdata_i(bus_wdata), .rdata_o(bank_rdata)
  );

  assign bus_rdata_oe = access && bus_rd;
  assign bus_rdata    = bus_rdata_oe ? bank_rdata : '0;

  p_ready_at_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |-> bus_ready);
  p_wait_needs_decode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |-> access);
  p_oe_needs_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> bus_rd);
endmodule

// File: tb/bus_periph_decoder_test.sv
module bus_periph_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        mio = 1'b0;
  logic        rd_a = 1'b0, wr_a = 1'b0, rd_b = 1'b0, wr_b = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata_a, rdata_b;
  logic        oe_a, oe_b, rdy_a, rdy_b;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bus_periph_decoder #(.MODE(bpd_pkg::MAP_MEMORY)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_mio(mio),
    .bus_rd(rd_a), .bus_wr(wr_a), .bus_wdata(wdata),
    .bus_rdata(rdata_a), .bus_rdata_oe(oe_a), .bus_ready(rdy_a)
  );

  bus_periph_decoder #(.MODE(bpd_pkg::MAP_ISOLATED)) uut_io (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_mio(mio),
    .bus_rd(rd_b), .bus_wr(wr_b), .bus_wdata(wdata),
    .bus_rdata(rdata_b), .bus_rdata_oe(oe_b), .bus_ready(rdy_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one bus access; io selects the isolated-mode instance
  task automatic access(input bit io, input logic [15:0] a, input logic m,
                        input bit r, input bit w, input logic [7:0] d,
                        output int waits, output logic [7:0] rdv, output logic oev);
    @(negedge clk);
    addr = a; mio = m; wdata = d;
    if (io) begin rd_b = r; wr_b = w; end else begin rd_a = r; wr_a = w; end
    waits = 0;
    #1;
    while (!(io ? rdy_b : rdy_a) && waits < 20) begin
      waits++;
      @(negedge clk); #1;
    end
    rdv = io ? rdata_b : rdata_a;
    oev = io ? oe_b : oe_a;
    @(negedge clk);
    rd_a = 0; wr_a = 0; rd_b = 0; wr_b = 0;
    #1;
    check((io ? rdy_b : rdy_a) == 1'b1, "R5 ready after strobes drop", io ? rdy_b : rdy_a, 1);
    check((io ? oe_b : oe_a) == 1'b0 && (io ? rdata_b : rdata_a) == 8'h00,
          "R8 idle read outputs", io ? rdata_b : rdata_a, 0);
  endtask

  task automatic test_reset_r1();
    int wt; logic [7:0] rv; logic oe;
    check(rdy_a && rdy_b, "R1 ready after reset", {rdy_a, rdy_b}, 3);
    check(!oe_a && !oe_b && rdata_a == 0 && rdata_b == 0, "R1 read outputs", rdata_a, 0);
    for (int i = 0; i < 4; i++) begin
      access(0, 16'h8000 + 16'(i), 0, 1, 0, 0, wt, rv, oe);
      check(rv == 8'h00 && oe, "R1 register reads zero", rv, 0);
    end
  endtask

  task automatic test_memmap_r2();
    int wt; logic [7:0] rv; logic oe;
    access(0, 16'h8001, 0, 0, 1, 8'hA5, wt, rv, oe);
    check(wt == 0, "R5 fast write no wait", wt, 0);
    check(oe == 0 && rv == 0, "R8 no read data during write", rv, 0);
    access(0, 16'h8001, 1, 1, 0, 0, wt, rv, oe);
    check(rv == 8'hA5 && oe, "R7 readback reg1", rv, 8'hA5);
    access(0, 16'hC001, 0, 1, 0, 0, wt, rv, oe);
    check(rv == 8'hA5, "R2 alias 0xC001", rv, 8'hA5);
    access(0, 16'h7FFD, 0, 0, 1, 8'h3C, wt, rv, oe);
    check(wt == 0, "R2 memory write keeps ready", wt, 0);
    access(0, 16'h8001, 0, 1, 0, 0, wt, rv, oe);
    check(rv == 8'hA5, "R2 memory write ignored", rv, 8'hA5);
    access(0, 16'h0002, 1, 1, 0, 0, wt, rv, oe);
    check(!oe && rv == 0, "R2 memory read no enable", rv, 0);
    access(0, 16'h0003, 1, 1, 0, 0, wt, rv, oe);
    check(wt == 0, "R2 memory read of slow index no wait", wt, 0);
  endtask

  task automatic test_slow_r6();
    int wt; logic [7:0] rv; logic oe;
    access(0, 16'h8003, 0, 0, 1, 8'h77, wt, rv, oe);
    check(wt == 3, "R6 slow write waits", wt, 3);
    access(0, 16'h8003, 0, 1, 0, 0, wt, rv, oe);
    check(wt == 3, "R6 slow read waits", wt, 3);
    check(rv == 8'h77 && oe, "R7 slow readback", rv, 8'h77);
    access(0, 16'h8002, 0, 1, 0, 0, wt, rv, oe);
    check(wt == 0, "R5 fast read after slow", wt, 0);
  endtask

  task automatic test_no_cmd_r9();
    @(negedge clk);
    addr = 16'h8003; mio = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1;
      check(rdy_a && rdy_b, "R9 address without strobe", {rdy_a, rdy_b}, 3);
      @(negedge clk);
    end
  endtask

  task automatic test_isolated_r3();
    int wt; logic [7:0] rv; logic oe;
    access(1, 16'h1234, 1, 0, 1, 8'h11, wt, rv, oe);
    check(wt == 0, "R3 io write no wait", wt, 0);
    access(1, 16'h0000, 1, 1, 0, 0, wt, rv, oe);
    check(rv == 8'h11 && oe, "R4 high bits ignored", rv, 8'h11);
    access(1, 16'h0000, 0, 0, 1, 8'h99, wt, rv, oe);
    check(wt == 0, "R3 memory-space write keeps ready", wt, 0);
    access(1, 16'h0000, 0, 1, 0, 0, wt, rv, oe);
    check(!oe && rv == 0, "R3 memory-space read no enable", rv, 0);
    access(1, 16'hFFF0, 1, 1, 0, 0, wt, rv, oe);
    check(rv == 8'h11, "R3 memory-space write ignored", rv, 8'h11);
    access(1, 16'hFF02, 1, 0, 1, 8'h5A, wt, rv, oe);
    access(1, 16'h0002, 1, 1, 0, 0, wt, rv, oe);
    check(rv == 8'h5A, "R4 0xFF02 aliases 0x0002", rv, 8'h5A);
    access(1, 16'hAB03, 1, 0, 1, 8'hC3, wt, rv, oe);
    check(wt == 3, "R6 io slow write waits", wt, 3);
    access(1, 16'h0003, 0, 1, 0, 0, wt, rv, oe);
    check(wt == 0 && !oe, "R3 memory-space slow index no wait", wt, 0);
    access(1, 16'h0003, 1, 1, 0, 0, wt, rv, oe);
    check(rv == 8'hC3 && wt == 3, "R7 io slow readback", rv, 8'hC3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    test_reset_r1();
    test_memmap_r2();
    test_slow_r6();
    test_no_cmd_r9();
    test_isolated_r3();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule